// File: doc/BRIEF.md
# Serial LED Matrix Register Interface

This block is the device side of a serial dot-matrix LED driver, recreated as synchronous logic in a system clock domain. A host drives four slow pins: a shift clock, an active-low chip select, a register-select line and serial data. The block oversamples those pins through a short synchronizer and detects three events: a rising shift-clock edge while selected, the falling edge of chip select, and the "select high, shift clock low" idle condition.

While selected, data shifts into either a 160-bit pixel shift register or an 8-bit command shift register. The target is chosen by the register-select level seen when chip select fell. When the host deselects and the shift clock rests low, the pixel shift register is copied into a parallel pixel latch, or the 7-bit command payload is copied into one of two command words. The pixel latch and the decoded command fields drive the outputs. The serial output either presents the last stage of the active shift register, so two instances chain into a 320-bit string, or follows the serial input directly, so a chain of instances receives one command together.

The PWM refresh, peak-current drive, oscillator and analog outputs are left to the logic that consumes these fields.

Top module: `ledmx_serial_if`

## Requirements
- R1: An active-low reset sets both command words and the command shift register to zero, so after reset pwm_level, peak_level, awake, dout_simul and osc_div8 all read 0, which is sleep.
- R2: When chip select falls with register-select low, each later rising shift-clock edge while chip select is low moves ser_din into the pixel shift register. After 160 edges and a latch, the first bit shifted appears on pix_bits[0] and the last on pix_bits[159]. Column c occupies bits 8c to 8c+7, and bit 8c is the unlit row.
- R3: pix_bits and the command words change only on a latch event. A latch event happens once each time chip select is high and the shift clock is low together after that condition was absent. The outputs hold their previous values throughout shifting.
- R4: Command bits shift in MSB first. On a latch with register-select captured high, a payload bit 7 of 0 loads command word 0 and a 1 loads command word 1, and the other word keeps its value.
- R5: Command word 0 drives pwm_level from bits 3:0, peak_level from bits 5:4 and awake from bit 6, where 0 means sleep.
- R6: Command word 1 drives dout_simul from bit 0 (1 = simultaneous output) and osc_div8 from bit 1 (1 = prescaler divides by 8).
- R7: With dout_simul at 0, ser_dout is the last stage of the selected shift register. That is the bit shifted in 160 edges earlier for pixels, or 8 edges earlier for commands.
- R8: With dout_simul at 1, ser_dout equals ser_din combinationally, so chained instances shift and latch the same command bits.
- R9: The register selection is taken when chip select falls. Changing ser_rs while chip select stays low does not redirect shifting or the following latch.
- R10: Feeding one instance's ser_dout into another's ser_din forms a 320-bit pixel chain and a 16-bit command chain. The first 160 pixel bits shifted end in the far instance.
- R11: Reset leaves the pixel shift register and pixel latch untouched, and pix_bits keeps its value through reset.
- R12: Rising shift-clock edges while chip select is high shift nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_ce | input | 1 | Active-low chip select |
| ser_rs | input | 1 | Register select: 0 pixels, 1 command |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out (chain tail or pass-through) |
| pix_bits | output | 160 | Latched pixel bits, column-major, column 0 lowest |
| pwm_level | output | 4 | PWM brightness field of command word 0 |
| peak_level | output | 2 | Peak-current field of command word 0 |
| awake | output | 1 | 1 = active, 0 = sleep |
| dout_simul | output | 1 | 1 = ser_dout follows ser_din |
| osc_div8 | output | 1 | 1 = external oscillator prescaler of 8 |

## Verification
A corrupted shift register shows first on ser_dout. In a chain it also shows on the far instance's pixels and command fields once the latch fires, so a model compared at every pin phase catches a bad bit within one serial phase of its shifting out. A wrong selection capture or a wrong word decode shows at the next latch as a changed field that should have held. A latch that fires during shifting, or fires twice, shows as pix_bits moving before chip select rises. The bench runs two chained instances so that the tail bits and the pass-through mode are checked through the second instance's outputs as well as directly.

// File: rtl/ledmx_pkg.sv
package ledmx_pkg;

    typedef enum logic {
        SEL_DOT  = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     clk_prev;
        logic     ce_prev;
        logic     latch_done;
        reg_sel_e sel;
    } det_state_t;

    localparam int PWM_LSB   = 0;
    localparam int PWM_W     = 4;
    localparam int PEAK_LSB  = 4;
    localparam int PEAK_W    = 2;
    localparam int AWAKE_BIT = 6;
    localparam int SIMUL_BIT = 0;
    localparam int DIV8_BIT  = 1;

endpackage

// File: rtl/ledmx_pin_sync.sv
module ledmx_pin_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] pins_out
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign pins_out = pins_in;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

            always_comb begin
                stage_d[0] = pins_in;
                for (int i = 1; i < STAGES; i++) begin
                    stage_d[i] = stage_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= {STAGES{RST_VAL}};
                end else begin
                    stage_q <= stage_d;
                end
            end

            assign pins_out = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ledmx_evt_det.sv
module ledmx_evt_det
    import ledmx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     s_clk,
    input  logic     s_ce,
    input  logic     s_rs,
    output logic     shift_ev,
    output logic     latch_ev,
    output reg_sel_e sel
);

    det_state_t st_d, st_q;
    logic       ce_fall;
    logic       latch_cond;

    always_comb begin
        st_d       = st_q;
        ce_fall    = st_q.ce_prev & ~s_ce;
        latch_cond = s_ce & ~s_clk;

        if (ce_fall) begin
            st_d.sel = s_rs ? SEL_CTRL : SEL_DOT;
        end

        shift_ev = ~s_ce & s_clk & ~st_q.clk_prev;
        latch_ev = latch_cond & ~st_q.latch_done;

        st_d.clk_prev   = s_clk;
        st_d.ce_prev    = s_ce;
        st_d.latch_done = latch_cond;

        sel = st_d.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{clk_prev: 1'b0, ce_prev: 1'b1, latch_done: 1'b1, sel: SEL_DOT};
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    latch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_ev |=> !latch_ev);

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_ce && !ce_fall) |=> $stable(st_q.sel));

endmodule

// File: rtl/ledmx_dot_reg.sv
module ledmx_dot_reg #(
    parameter int DOT_BITS = 160
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                din,
    input  logic                latch_en,
    output logic [DOT_BITS-1:0] pix,
    output logic                tail
);

    typedef struct packed {
        logic [DOT_BITS-1:0] sr;
        logic [DOT_BITS-1:0] lat;
    } dot_state_t;

    dot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {din, st_q.sr[DOT_BITS-1:1]};
        end
        if (latch_en) begin
            st_d.lat = st_q.sr;
        end
    end

    // pixel storage is deliberately left out of reset
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pix  = st_q.lat;
    assign tail = st_q.sr[0];

    // R12
    dot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.sr));

    // R3
    pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(pix));

endmodule

// File: rtl/ledmx_ctrl_reg.sv
module ledmx_ctrl_reg #(
    parameter int CTRL_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 din,
    input  logic                 latch_en,
    output logic [CTRL_BITS-2:0] word0,
    output logic [CTRL_BITS-2:0] word1,
    output logic                 tail
);

    localparam int WORD_W = CTRL_BITS - 1;
    localparam int MSB    = CTRL_BITS - 1;

    typedef struct packed {
        logic [CTRL_BITS-1:0] sr;
        logic [WORD_W-1:0]    w0;
        logic [WORD_W-1:0]    w1;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {st_q.sr[CTRL_BITS-2:0], din};
        end
        if (latch_en) begin
            if (st_q.sr[MSB]) begin
                st_d.w1 = st_q.sr[WORD_W-1:0];
            end else begin
                st_d.w0 = st_q.sr[WORD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word0 = st_q.w0;
    assign word1 = st_q.w1;
    assign tail  = st_q.sr[MSB];

    // R4
    keep_w1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && !st_q.sr[MSB]) |=> $stable(word1));

    // R4
    keep_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && st_q.sr[MSB]) |=> $stable(word0));

endmodule

// File: rtl/ledmx_serial_if.sv
module ledmx_serial_if
    import ledmx_pkg::*;
#(
    parameter int DOT_BITS    = 160,
    parameter int CTRL_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                ser_ce,
    input  logic                ser_rs,
    input  logic                ser_din,
    output logic                ser_dout,
    output logic [DOT_BITS-1:0] pix_bits,
    output logic [PWM_W-1:0]    pwm_level,
    output logic [PEAK_W-1:0]   peak_level,
    output logic                awake,
    output logic                dout_simul,
    output logic                osc_div8
);

    localparam int WORD_W = CTRL_BITS - 1;
    localparam int PIN_W  = 4;

    logic [PIN_W-1:0]  pins_raw, pins_s;
    logic              s_clk, s_ce, s_rs, s_din;
    logic              shift_ev, latch_ev;
    reg_sel_e          sel;
    logic              dot_tail, ctrl_tail;
    logic [WORD_W-1:0] word0, word1;

    assign pins_raw = {ser_clk, ser_ce, ser_rs, ser_din};

    ledmx_pin_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_in  (pins_raw),
        .pins_out (pins_s)
    );

    assign {s_clk, s_ce, s_rs, s_din} = pins_s;

    ledmx_evt_det u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_clk    (s_clk),
        .s_ce     (s_ce),
        .s_rs     (s_rs),
        .shift_ev (shift_ev),
        .latch_ev (latch_ev),
        .sel      (sel)
    );

    ledmx_dot_reg #(.DOT_BITS(DOT_BITS)) u_dot (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_ev && sel == SEL_DOT),
        .din      (s_din),
        .latch_en (latch_ev && sel == SEL_DOT),
        .pix      (pix_bits),
        .tail     (dot_tail)
    );

    ledmx_ctrl_reg #(.CTRL_BITS(CTRL_BITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_ev && sel == SEL_CTRL),
        .din      (s_din),
        .latch_en (latch_ev && sel == SEL_CTRL),
        .word0    (word0),
        .word1    (word1),
        .tail     (ctrl_tail)
    );

    assign pwm_level  = word0[PWM_LSB +: PWM_W];
    assign peak_level = word0[PEAK_LSB +: PEAK_W];
    assign awake      = word0[AWAKE_BIT];
    assign dout_simul = word1[SIMUL_BIT];
    assign osc_div8   = word1[DIV8_BIT];

    always_comb begin
        if (dout_simul) begin
            ser_dout = ser_din;
        end else if (sel == SEL_CTRL) begin
            ser_dout = ctrl_tail;
        end else begin
            ser_dout = dot_tail;
        end
    end

endmodule

// File: tb/ledmx_serial_if_bench.sv
module ledmx_serial_if_bench;

    localparam int PH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p_clk = 1'b0, p_ce = 1'b1, p_rs = 1'b0, p_din = 1'b0;
    logic a_dout, b_dout;
    logic [159:0] a_pix, b_pix;
    logic [3:0] a_pwm, b_pwm;
    logic [1:0] a_peak, b_peak;
    logic a_awake, b_awake, a_sim, b_sim, a_div, b_div;

    int checks = 0;
    int fails  = 0;
    bit reported = 0;

    always #4 clk = ~clk;

    ledmx_serial_if u_ledmx_serial_if (
        .clk(clk), .rst_n(rst_n), .ser_clk(p_clk), .ser_ce(p_ce), .ser_rs(p_rs),
        .ser_din(p_din), .ser_dout(a_dout), .pix_bits(a_pix), .pwm_level(a_pwm),
        .peak_level(a_peak), .awake(a_awake), .dout_simul(a_sim), .osc_div8(a_div)
    );

    ledmx_serial_if u_ledmx_serial_if_b (
        .clk(clk), .rst_n(rst_n), .ser_clk(p_clk), .ser_ce(p_ce), .ser_rs(p_rs),
        .ser_din(a_dout), .ser_dout(b_dout), .pix_bits(b_pix), .pwm_level(b_pwm),
        .peak_level(b_peak), .awake(b_awake), .dout_simul(b_sim), .osc_div8(b_div)
    );

    // behavioural reference model
    bit a_dot[$], b_dot[$], a_ctl[$], b_ctl[$];
    bit [159:0] a_lat, b_lat;
    bit [6:0] a_w0, a_w1, b_w0, b_w1;
    bit m_sel, m_clk, m_ce, m_done;
    int dot_shifts = 0;
    bit pix_known = 0;

    task automatic model_reset();
        a_ctl = {}; b_ctl = {};
        for (int i = 0; i < 8; i++) begin a_ctl.push_back(1'b0); b_ctl.push_back(1'b0); end
        a_w0 = '0; a_w1 = '0; b_w0 = '0; b_w1 = '0;
        m_sel = 0; m_clk = 0; m_ce = 1; m_done = 1;
    endtask

    function automatic bit a_exp_dout();
        if (a_w1[0]) return p_din;
        return m_sel ? a_ctl[0] : a_dot[0];
    endfunction

    function automatic bit b_exp_dout();
        if (b_w1[0]) return a_exp_dout();
        return m_sel ? b_ctl[0] : b_dot[0];
    endfunction

    task automatic model_shift(input bit d);
        bit a_out;
        a_out = a_w1[0] ? d : (m_sel ? a_ctl[0] : a_dot[0]);
        if (m_sel) begin
            a_ctl.push_back(d);     void'(a_ctl.pop_front());
            b_ctl.push_back(a_out); void'(b_ctl.pop_front());
        end else begin
            a_dot.push_back(d);     void'(a_dot.pop_front());
            b_dot.push_back(a_out); void'(b_dot.pop_front());
            if (dot_shifts < 1000) dot_shifts++;
        end
    endtask

    task automatic model_latch();
        bit [7:0] wa, wb;
        if (m_sel) begin
            for (int i = 0; i < 8; i++) begin wa[7-i] = a_ctl[i]; wb[7-i] = b_ctl[i]; end
            if (wa[7]) a_w1 = wa[6:0]; else a_w0 = wa[6:0];
            if (wb[7]) b_w1 = wb[6:0]; else b_w0 = wb[6:0];
        end else begin
            for (int i = 0; i < 160; i++) begin a_lat[i] = a_dot[i]; b_lat[i] = b_dot[i]; end
            if (dot_shifts >= 320) pix_known = 1;
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "A fields", 160'({a_pwm, a_peak, a_awake, a_sim, a_div}),
            160'({a_w0[3:0], a_w0[5:4], a_w0[6], a_w1[0], a_w1[1]}));
        chk(tag, "B fields", 160'({b_pwm, b_peak, b_awake, b_sim, b_div}),
            160'({b_w0[3:0], b_w0[5:4], b_w0[6], b_w1[0], b_w1[1]}));
        if (pix_known) begin
            chk(tag, "A pixels", a_pix, a_lat);
            chk(tag, "B pixels", b_pix, b_lat);
        end
        if (m_sel || dot_shifts >= 320 || a_w1[0]) chk(tag, "A dout", 160'(a_dout), 160'(a_exp_dout()));
        if (m_sel || dot_shifts >= 320 || (b_w1[0] && a_w1[0])) chk(tag, "B dout", 160'(b_dout), 160'(b_exp_dout()));
    endtask

    task automatic set_pins(input bit c, input bit e, input bit r, input bit d, input string tag);
        bit cond;
        @(negedge clk);
        p_clk = c; p_ce = e; p_rs = r; p_din = d;
        if (m_ce && !e) m_sel = r;
        if (!e && c && !m_clk) model_shift(d);
        cond = e && !c;
        if (cond && !m_done) model_latch();
        m_done = cond; m_clk = c; m_ce = e;
        repeat (PH) @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic xfer(input bit rs, input bit bits[$], input bit flip, input string tag);
        bit r;
        bit last;
        last = 0;
        set_pins(0, 1, rs, 0, tag);
        set_pins(0, 0, rs, 0, tag);
        r = rs;
        if (flip) begin r = !rs; set_pins(0, 0, r, 0, "R9"); end
        foreach (bits[i]) begin
            set_pins(0, 0, r, bits[i], tag);
            set_pins(1, 0, r, bits[i], tag);
            last = bits[i];
        end
        set_pins(1, 1, r, last, tag);
        set_pins(0, 1, r, last, "R3");
    endtask

    task automatic make_dots(output bit q[$], input int n, input int seed);
        q = {};
        for (int i = 0; i < n; i++) q.push_back(((i * seed + (i >> 3)) % 3) == 0);
    endtask

    task automatic make_bytes(output bit q[$], input bit [7:0] b0, input bit [7:0] b1, input bit two);
        q = {};
        for (int i = 7; i >= 0; i--) q.push_back(b0[i]);
        if (two) for (int i = 7; i >= 0; i--) q.push_back(b1[i]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        repeat (PH) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        bit q[$];
        for (int i = 0; i < 160; i++) begin a_dot.push_back(1'b0); b_dot.push_back(1'b0); end
        do_reset();
        check_all("R1");

        // R10: first load fills both instances through the chain
        make_dots(q, 320, 5);
        xfer(0, q, 0, "R10");
        chk("R10", "B first bit", 160'(b_pix[0]), 160'(q[0]));
        chk("R2", "A last bit", 160'(a_pix[159]), 160'(q[319]));

        // R5: two command words through the 16-bit chain, B gets first byte
        make_bytes(q, 8'h65, 8'h4A, 1);
        xfer(1, q, 0, "R5");
        chk("R5", "B pwm", 160'(b_pwm), 160'(4'h5));
        chk("R5", "A awake", 160'(a_awake), 160'(1'b1));

        // R4 / R6: word 1 load leaves word 0 alone
        make_bytes(q, 8'h82, 8'h82, 1);
        xfer(1, q, 0, "R4");
        chk("R6", "A div8", 160'(a_div), 160'(1'b1));
        chk("R4", "A pwm kept", 160'(a_pwm), 160'(4'hA));

        make_dots(q, 320, 11);
        xfer(0, q, 0, "R2");
        make_dots(q, 320, 3);
        xfer(0, q, 0, "R3");
        make_bytes(q, 8'h4F, 8'h70, 1);
        xfer(1, q, 0, "R7");

        // R12: clock pulses with chip select high
        set_pins(0, 1, 0, 1, "R12");
        for (int k = 0; k < 4; k++) begin
            set_pins(1, 1, 0, 1, "R12");
            set_pins(0, 1, 0, 1, "R12");
        end

        // R9: selection flips after chip select falls
        make_dots(q, 320, 7);
        xfer(0, q, 1, "R9");

        // R11: reset keeps pixels
        do_reset();
        check_all("R11");
        chk("R1", "A awake after reset", 160'(a_awake), 160'(1'b0));

        // R8: enter simultaneous mode on both, then broadcast
        make_bytes(q, 8'h81, 8'h81, 1);
        xfer(1, q, 0, "R6");
        make_bytes(q, 8'h5C, 8'h00, 0);
        xfer(1, q, 0, "R8");
        chk("R8", "B gets broadcast", 160'(b_pwm), 160'(4'hC));
        make_dots(q, 160, 13);
        xfer(0, q, 0, "R8");

        report();
    end

endmodule